// File: doc/BRIEF.md
# AXI Host Stream Bridge

This block is a slave on an AXI4 port with 32-bit data. It connects a bus master to a host link that is 16 bits wide. The master pushes 32-bit words into a transmit queue by writing one fixed address. It pops words that arrived from the host by reading a second address. A read of the push address returns the number of complete words waiting in the receive queue, and a write to a control address pulses a reset line toward the host. Bursts are treated as fixed-address bursts, so a burst of N beats to a queue address moves N consecutive queue entries. Accesses to any other address complete with an OKAY response and have no effect.

On the host side the bridge drives a 16-bit valid/ready output stream and accepts a 16-bit valid/ready input stream. Each outgoing word is split into two halves, and each pair of incoming halves is packed back into one word. The two directions use the same half ordering, so a host that loops its output back to its input returns the words in the order they were written. The read and write paths of the bus run independently, and each path handles one transaction at a time with a single ID.

Top module: `hstream_axi_bridge`

## Requirements
- R1: After reset `aw_ready`, `ar_ready` and `hin_ready` are 1, and `w_ready`, `b_valid`, `r_valid`, `hout_valid` and `host_rst` are 0.
- R2: A write burst to address 0x00 pushes its beats into the transmit queue in order. `b_valid` rises only after the beat carrying `w_last` is accepted, with `b_id` equal to the accepted `aw_id` and `b_resp` = 2'b00 (OKAY).
- R3: Each transmit word leaves on `hout_data` as two halves, bits [15:0] first and then bits [31:16]. While `hout_valid` is 1 and `hout_ready` is 0, `hout_valid` stays 1 and `hout_data` does not change.
- R4: Two accepted host-input halves form one word, with the first half in bits [15:0] and the second half in bits [31:16].
- R5: A read of address 0x00 returns, zero-extended, the number of complete words in the receive queue, captured when the read address is accepted. A lone buffered half is not counted.
- R6: A read burst of `ar_len`+1 beats to address 0x04 pops that many words in arrival order. `r_last` is 1 only on the final beat, `r_id` echoes `ar_id`, and `r_resp` = 2'b00.
- R7: A read of address 0x04 while the receive queue is empty holds `r_valid` at 0 until a complete word arrives, and then returns that word.
- R8: A write to address 0x7C drives `host_rst` high for exactly one cycle, in the cycle after the beat carrying `w_last` is accepted. The write data is ignored and nothing enters the transmit queue.
- R9: When the transmit queue (8 words) is full, `w_ready` stays 0 for push writes and no beat is lost. When the receive queue (8 words) is full, `hin_ready` is 0 for the half that would complete a word.
- R10: With `hout` looped back to `hin`, words read from address 0x04 equal the words written to address 0x00, in the same order.
- R11: A write to an unmapped address is answered with OKAY and pushes nothing. A read of an unmapped address returns zero data on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write byte address |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data beat |
| w_last | input | 1 | Final write beat |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response code (always OKAY) |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read byte address |
| ar_len | input | 8 | Read beats minus one |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | ID_W | Read data ID |
| r_data | output | DATA_W | Read data beat |
| r_resp | output | 2 | Read response code (always OKAY) |
| r_last | output | 1 | Final read beat |
| hout_valid | output | 1 | Host output half valid |
| hout_ready | input | 1 | Host output half ready |
| hout_data | output | HOST_W | Host output half |
| hin_valid | input | 1 | Host input half valid |
| hin_ready | output | 1 | Host input half ready |
| hin_data | input | HOST_W | Host input half |
| host_rst | output | 1 | One-cycle reset pulse toward the host |

## Verification
Transmit traffic is tested three ways. A four-beat burst is sent with the host stalled, which shows whether the half order is right and whether the output holds during a stall. A ten-beat burst is sent into the eight-entry queue, which separates correct backpressure from lost or duplicated beats. A looped-back run compares the whole round trip word for word. Receive traffic uses an odd number of halves, which shows whether a pending half is wrongly counted or mispacked. It also uses a pop issued on an empty queue, which separates a held `r_valid` from a premature one, and a fill past capacity, which shows whether the word-completing half is refused while earlier halves are still taken. Control and unmapped writes are checked by watching the reset pulse timing and confirming that nothing appears on the host output.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

   typedef enum logic [1:0] {
      WT_PUSH = 2'd0,
      WT_CTRL = 2'd1,
      WT_DROP = 2'd2
   } wr_tgt_e;

   typedef enum logic [1:0] {
      RT_POP   = 2'd0,
      RT_COUNT = 2'd1,
      RT_ZERO  = 2'd2
   } rd_tgt_e;

   typedef enum logic [1:0] {
      WS_ADDR = 2'd0,
      WS_DATA = 2'd1,
      WS_RESP = 2'd2
   } wr_state_e;

   typedef enum logic {
      RS_ADDR = 1'b0,
      RS_DATA = 1'b1
   } rd_state_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;
   localparam int unsigned LEN_W = 8;

endpackage

// File: rtl/hsb_fifo.sv
module hsb_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = PW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full,
   output logic [CW-1:0]    count
);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_depth_bad
      $error("hsb_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [CW-1:0]    wp_q;
   logic [CW-1:0]    rp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp_q[PW-1:0]] <= push_data;
   end

   assign count = wp_q - rp_q;
   assign empty = (wp_q == rp_q);
   assign full  = (count == CW'(DEPTH));
   assign head  = mem[rp_q[PW-1:0]];

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

endmodule

// File: rtl/hsb_tx_split.sv
module hsb_tx_split #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned PIECE_W = 16,
   localparam int unsigned N  = WORD_W / PIECE_W,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_valid,
   input  logic [WORD_W-1:0]  word,
   output logic               word_take,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [PIECE_W-1:0] out_data
);

   if (N < 2 || (1 << IW) != N || N * PIECE_W != WORD_W) begin : g_ratio_bad
      $error("hsb_tx_split: WORD_W must be a power-of-two multiple (>=2) of PIECE_W");
   end

   logic [PIECE_W-1:0] pieces [N];
   logic [IW-1:0]      idx_q;
   logic               fire;
   logic               at_last;

   for (genvar g = 0; g < N; g++) begin : g_piece
      assign pieces[g] = word[g*PIECE_W +: PIECE_W];
   end

   assign out_valid = word_valid;
   assign out_data  = pieces[idx_q];
   assign fire      = out_valid && out_ready;
   assign at_last   = (idx_q == IW'(N - 1));
   assign word_take = fire && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (fire) begin
         idx_q <= at_last ? '0 : idx_q + 1'b1;
      end
   end

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/hsb_rx_pack.sv
module hsb_rx_pack #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned PIECE_W = 16,
   localparam int unsigned N  = WORD_W / PIECE_W,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
   localparam int unsigned HW = (N - 1) * PIECE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [PIECE_W-1:0] in_data,
   input  logic               room,
   output logic               word_push,
   output logic [WORD_W-1:0]  word
);

   if (N < 2 || (1 << IW) != N || N * PIECE_W != WORD_W) begin : g_ratio_bad
      $error("hsb_rx_pack: WORD_W must be a power-of-two multiple (>=2) of PIECE_W");
   end

   logic [IW-1:0] idx_q;
   logic [HW-1:0] held_q;
   logic          at_last;
   logic          fire;

   assign at_last   = (idx_q == IW'(N - 1));
   assign in_ready  = !at_last || room;
   assign fire      = in_valid && in_ready;
   assign word_push = fire && at_last;
   assign word      = {in_data, held_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         held_q <= '0;
      end else if (fire) begin
         if (at_last) begin
            idx_q <= '0;
         end else begin
            held_q[idx_q*PIECE_W +: PIECE_W] <= in_data;
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // R4
   piece_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_push |=> in_ready);

endmodule

// File: rtl/hsb_wr_ctrl.sv
module hsb_wr_ctrl
   import hsb_pkg::*;
#(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] PUSH_ADDR = 'h00,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h7C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ID_W-1:0]   aw_id,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic              w_last,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [ID_W-1:0]   b_id,
   output logic [1:0]        b_resp,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_full,
   output logic              ctrl_pulse
);

   wr_state_e       state_q;
   wr_tgt_e         tgt_q;
   wr_tgt_e         tgt_dec;
   logic [ID_W-1:0] id_q;
   logic            aw_fire;
   logic            w_fire;
   logic            b_fire;

   always_comb begin
      if (aw_addr == PUSH_ADDR)      tgt_dec = WT_PUSH;
      else if (aw_addr == CTRL_ADDR) tgt_dec = WT_CTRL;
      else                           tgt_dec = WT_DROP;
   end

   assign aw_ready = (state_q == WS_ADDR);
   assign w_ready  = (state_q == WS_DATA) && !(tgt_q == WT_PUSH && tx_full);
   assign b_valid  = (state_q == WS_RESP);
   assign b_id     = id_q;
   assign b_resp   = RESP_OKAY;

   assign aw_fire = aw_valid && aw_ready;
   assign w_fire  = w_valid && w_ready;
   assign b_fire  = b_valid && b_ready;

   assign tx_push = w_fire && (tgt_q == WT_PUSH);
   assign tx_data = w_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= WS_ADDR;
         tgt_q      <= WT_DROP;
         id_q       <= '0;
         ctrl_pulse <= 1'b0;
      end else begin
         ctrl_pulse <= w_fire && w_last && (tgt_q == WT_CTRL);
         case (state_q)
            WS_ADDR: if (aw_fire) begin
               tgt_q   <= tgt_dec;
               id_q    <= aw_id;
               state_q <= WS_DATA;
            end
            WS_DATA: if (w_fire && w_last) state_q <= WS_RESP;
            WS_RESP: if (b_fire)           state_q <= WS_ADDR;
            default: state_q <= WS_ADDR;
         endcase
      end
   end

   // R2
   b_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_valid) |-> $past(w_valid && w_ready && w_last));

   // R2
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_valid && !b_ready |=> b_valid && $stable(b_id));

   // R8
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_pulse |=> !ctrl_pulse);

endmodule

// File: rtl/hsb_rd_ctrl.sv
module hsb_rd_ctrl
   import hsb_pkg::*;
#(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 4,
   parameter logic [ADDR_W-1:0] POP_ADDR   = 'h04,
   parameter logic [ADDR_W-1:0] COUNT_ADDR = 'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ID_W-1:0]   ar_id,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [LEN_W-1:0]  ar_len,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [ID_W-1:0]   r_id,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              r_last,
   input  logic [DATA_W-1:0] rx_head,
   input  logic              rx_empty,
   input  logic [CNT_W-1:0]  rx_count,
   output logic              rx_pop
);

   if (CNT_W >= DATA_W) begin : g_cnt_bad
      $error("hsb_rd_ctrl: count width must be narrower than the data width");
   end

   rd_state_e         state_q;
   rd_tgt_e           tgt_q;
   rd_tgt_e           tgt_dec;
   logic [ID_W-1:0]   id_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  beat_q;
   logic [DATA_W-1:0] cnt_q;
   logic              ar_fire;
   logic              r_fire;

   always_comb begin
      if (ar_addr == POP_ADDR)        tgt_dec = RT_POP;
      else if (ar_addr == COUNT_ADDR) tgt_dec = RT_COUNT;
      else                            tgt_dec = RT_ZERO;
   end

   always_comb begin
      case (tgt_q)
         RT_POP:   r_data = rx_head;
         RT_COUNT: r_data = cnt_q;
         default:  r_data = '0;
      endcase
   end

   assign ar_ready = (state_q == RS_ADDR);
   assign r_valid  = (state_q == RS_DATA) && !(tgt_q == RT_POP && rx_empty);
   assign r_last   = (beat_q == len_q);
   assign r_id     = id_q;
   assign r_resp   = RESP_OKAY;

   assign ar_fire = ar_valid && ar_ready;
   assign r_fire  = r_valid && r_ready;
   assign rx_pop  = r_fire && (tgt_q == RT_POP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RS_ADDR;
         tgt_q   <= RT_ZERO;
         id_q    <= '0;
         len_q   <= '0;
         beat_q  <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            RS_ADDR: if (ar_fire) begin
               tgt_q   <= tgt_dec;
               id_q    <= ar_id;
               len_q   <= ar_len;
               beat_q  <= '0;
               cnt_q   <= {{(DATA_W-CNT_W){1'b0}}, rx_count};
               state_q <= RS_DATA;
            end
            RS_DATA: if (r_fire) begin
               if (r_last) state_q <= RS_ADDR;
               beat_q <= beat_q + 1'b1;
            end
            default: state_q <= RS_ADDR;
         endcase
      end
   end

   // R6
   r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid && !r_ready |=> r_valid && $stable(r_data) && $stable(r_last));

   // R6
   last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid && r_ready && r_last |=> ar_ready && !r_valid);

endmodule

// File: rtl/hstream_axi_bridge.sv
module hstream_axi_bridge
   import hsb_pkg::*;
#(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned HOST_W   = 16,
   parameter int unsigned TX_DEPTH = 8,
   parameter int unsigned RX_DEPTH = 8,
   parameter logic [ADDR_W-1:0] PUSH_ADDR  = 'h00,
   parameter logic [ADDR_W-1:0] COUNT_ADDR = 'h00,
   parameter logic [ADDR_W-1:0] POP_ADDR   = 'h04,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h7C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ID_W-1:0]   aw_id,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic              w_last,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [ID_W-1:0]   b_id,
   output logic [1:0]        b_resp,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ID_W-1:0]   ar_id,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [7:0]        ar_len,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [ID_W-1:0]   r_id,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              r_last,
   output logic              hout_valid,
   input  logic              hout_ready,
   output logic [HOST_W-1:0] hout_data,
   input  logic              hin_valid,
   output logic              hin_ready,
   input  logic [HOST_W-1:0] hin_data,
   output logic              host_rst
);

   localparam int unsigned TX_CW = $clog2(TX_DEPTH) + 1;
   localparam int unsigned RX_CW = $clog2(RX_DEPTH) + 1;

   if (PUSH_ADDR == CTRL_ADDR) begin : g_wmap_bad
      $error("hstream_axi_bridge: push and control addresses overlap");
   end
   if (POP_ADDR == COUNT_ADDR) begin : g_rmap_bad
      $error("hstream_axi_bridge: pop and count addresses overlap");
   end
   if (LEN_W != 8) begin : g_len_bad
      $error("hstream_axi_bridge: burst length field must be 8 bits");
   end

   logic              tx_push;
   logic [DATA_W-1:0] tx_wdata;
   logic              tx_pop;
   logic [DATA_W-1:0] tx_head;
   logic              tx_empty;
   logic              tx_full;
   logic [TX_CW-1:0]  tx_count;

   logic              rx_push;
   logic [DATA_W-1:0] rx_wdata;
   logic              rx_pop;
   logic [DATA_W-1:0] rx_head;
   logic              rx_empty;
   logic              rx_full;
   logic [RX_CW-1:0]  rx_count;

   hsb_wr_ctrl #(
      .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PUSH_ADDR(PUSH_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) wr_i (
      .clk(clk), .rst_n(rst_n),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
      .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
      .tx_push(tx_push), .tx_data(tx_wdata), .tx_full(tx_full),
      .ctrl_pulse(host_rst)
   );

   hsb_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) tx_q_i (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .push_data(tx_wdata),
      .pop(tx_pop), .head(tx_head),
      .empty(tx_empty), .full(tx_full), .count(tx_count)
   );

   hsb_tx_split #(.WORD_W(DATA_W), .PIECE_W(HOST_W)) split_i (
      .clk(clk), .rst_n(rst_n),
      .word_valid(!tx_empty), .word(tx_head), .word_take(tx_pop),
      .out_valid(hout_valid), .out_ready(hout_ready), .out_data(hout_data)
   );

   hsb_rx_pack #(.WORD_W(DATA_W), .PIECE_W(HOST_W)) pack_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(hin_valid), .in_ready(hin_ready), .in_data(hin_data),
      .room(!rx_full), .word_push(rx_push), .word(rx_wdata)
   );

   hsb_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) rx_q_i (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .push_data(rx_wdata),
      .pop(rx_pop), .head(rx_head),
      .empty(rx_empty), .full(rx_full), .count(rx_count)
   );

   hsb_rd_ctrl #(
      .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(RX_CW),
      .POP_ADDR(POP_ADDR), .COUNT_ADDR(COUNT_ADDR)
   ) rd_i (
      .clk(clk), .rst_n(rst_n),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
      .ar_len(ar_len),
      .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
      .r_resp(r_resp), .r_last(r_last),
      .rx_head(rx_head), .rx_empty(rx_empty), .rx_count(rx_count), .rx_pop(rx_pop)
   );

   // R9
   tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= TX_CW'(TX_DEPTH));

   // R8
   ctrl_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst |-> $stable(tx_count) || tx_pop);

endmodule

// File: tb/hstream_axi_bridge_tb_top.sv
module hstream_axi_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        aw_valid = 1'b0, w_valid = 1'b0, w_last = 1'b0, b_ready = 1'b0;
   logic        ar_valid = 1'b0, r_ready = 1'b0;
   logic [3:0]  aw_id = '0, ar_id = '0;
   logic [7:0]  aw_addr = '0, ar_addr = '0, ar_len = '0;
   logic [31:0] w_data = '0;
   logic        aw_ready, w_ready, b_valid, ar_ready, r_valid, r_last, host_rst;
   logic [3:0]  b_id, r_id;
   logic [1:0]  b_resp, r_resp;
   logic [31:0] r_data;
   logic        hout_valid, hin_ready;
   logic [15:0] hout_data;
   logic        loop_en = 1'b0;
   logic        tb_hout_ready = 1'b0, tb_hin_valid = 1'b0;
   logic [15:0] tb_hin_data = '0;
   logic        hout_ready, hin_valid;
   logic [15:0] hin_data;

   assign hout_ready = loop_en ? hin_ready  : tb_hout_ready;
   assign hin_valid  = loop_en ? hout_valid : tb_hin_valid;
   assign hin_data   = loop_en ? hout_data  : tb_hin_data;

   always #4 clk = ~clk;

   hstream_axi_bridge dut_i (
      .clk(clk), .rst_n(rst_n),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
      .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
      .ar_len(ar_len),
      .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
      .r_resp(r_resp), .r_last(r_last),
      .hout_valid(hout_valid), .hout_ready(hout_ready), .hout_data(hout_data),
      .hin_valid(hin_valid), .hin_ready(hin_ready), .hin_data(hin_data),
      .host_rst(host_rst)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc = 0, w_beats = 0, w_cyc = 0, rst_cnt = 0, rst_cyc = 0;
   logic [15:0] hq [$];
   logic [31:0] wbuf [16];
   logic [31:0] rbuf [16];
   logic        rlast_b [16];
   logic [3:0]  rid_b;
   logic        early_b;

   // monitor, sampled well after the falling edge, before the next rising edge
   always @(negedge clk) begin
      #2;
      cyc++;
      if (hout_valid && hout_ready) hq.push_back(hout_data);
      if (w_valid && w_ready) begin w_beats++; w_cyc = cyc; end
      if (host_rst) begin rst_cnt++; rst_cyc = cyc; end
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic aw_send(logic [7:0] a, logic [3:0] id);
      @(negedge clk);
      aw_valid = 1'b1; aw_addr = a; aw_id = id;
      #1;
      while (!aw_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      aw_valid = 1'b0;
   endtask

   task automatic w_send(int n);
      early_b = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (i > 0) @(negedge clk);
         w_valid = 1'b1; w_data = wbuf[i]; w_last = (i == n - 1);
         #1;
         while (!w_ready) begin
            if (b_valid) early_b = 1'b1;
            @(negedge clk); #1;
         end
         if (b_valid) early_b = 1'b1;
         @(posedge clk);
      end
      @(negedge clk);
      w_valid = 1'b0; w_last = 1'b0;
   endtask

   task automatic b_get(logic [3:0] exp_id, string req);
      b_ready = 1'b1;
      #1;
      while (!b_valid) begin @(negedge clk); #1; end
      chk(req, "b_id", 32'(b_id), 32'(exp_id));
      chk(req, "b_resp", 32'(b_resp), 32'h0);
      @(posedge clk);
      @(negedge clk);
      b_ready = 1'b0;
   endtask

   task automatic ar_send(logic [7:0] a, logic [3:0] id, logic [7:0] len);
      @(negedge clk);
      ar_valid = 1'b1; ar_addr = a; ar_id = id; ar_len = len;
      #1;
      while (!ar_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
   endtask

   task automatic r_collect(int n);
      r_ready = 1'b1;
      for (int i = 0; i < n; i++) begin
         #1;
         while (!r_valid) begin @(negedge clk); #1; end
         rbuf[i] = r_data; rlast_b[i] = r_last; rid_b = r_id;
         @(posedge clk);
         @(negedge clk);
      end
      r_ready = 1'b0;
   endtask

   task automatic hin_send(logic [15:0] d);
      @(negedge clk);
      tb_hin_valid = 1'b1; tb_hin_data = d;
      #1;
      while (!hin_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      tb_hin_valid = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      chk("R1", "aw_ready", 32'(aw_ready), 32'h1);
      chk("R1", "ar_ready", 32'(ar_ready), 32'h1);
      chk("R1", "hin_ready", 32'(hin_ready), 32'h1);
      chk("R1", "w_ready/b_valid/r_valid", {29'b0, w_ready, b_valid, r_valid}, 32'h0);
      chk("R1", "hout_valid/host_rst", {30'b0, hout_valid, host_rst}, 32'h0);
   endtask

   task automatic t_push_burst;
      tb_hout_ready = 1'b0;
      hq.delete();
      for (int i = 0; i < 4; i++) wbuf[i] = 32'hC0DE_0000 + 32'(i) * 32'h0001_0101;
      aw_send(8'h00, 4'd3);
      w_send(4);
      chk("R2", "b_valid before last beat", 32'(early_b), 32'h0);
      b_get(4'd3, "R2");
      #1;
      chk("R3", "first half while stalled", {15'b0, hout_valid, hout_data},
          {15'b0, 1'b1, wbuf[0][15:0]});
      wait_cyc(3); #1;
      chk("R3", "half held during stall", {15'b0, hout_valid, hout_data},
          {15'b0, 1'b1, wbuf[0][15:0]});
      @(negedge clk);
      tb_hout_ready = 1'b1;
      wait_cyc(20);
      chk("R3", "halves emitted", 32'(hq.size()), 32'd8);
      for (int i = 0; i < 4 && hq.size() == 8; i++) begin
         chk("R3", "low half", 32'(hq[2*i]), 32'(wbuf[i][15:0]));
         chk("R3", "high half", 32'(hq[2*i+1]), 32'(wbuf[i][31:16]));
      end
   endtask

   task automatic t_tx_full;
      int base;
      tb_hout_ready = 1'b0;
      hq.delete();
      for (int i = 0; i < 10; i++) wbuf[i] = 32'hA000_0000 + 32'(i) * 32'h0000_0111;
      aw_send(8'h00, 4'd2);
      base = w_beats;
      fork
         w_send(10);
         begin
            wait_cyc(30); #1;
            chk("R9", "beats accepted with queue full", 32'(w_beats - base), 32'd8);
            chk("R9", "w_ready while full", 32'(w_ready), 32'h0);
            chk("R9", "b_valid while full", 32'(b_valid), 32'h0);
            @(negedge clk);
            tb_hout_ready = 1'b1;
         end
      join
      b_get(4'd2, "R9");
      wait_cyc(40);
      chk("R9", "halves after drain", 32'(hq.size()), 32'd20);
      for (int i = 0; i < 10 && hq.size() == 20; i++)
         chk("R9", "drained word", {hq[2*i+1], hq[2*i]}, wbuf[i]);
   endtask

   task automatic t_pack_count;
      hin_send(16'h1111); hin_send(16'h2222); hin_send(16'h3333);
      hin_send(16'h4444); hin_send(16'h5555);
      ar_send(8'h00, 4'd7, 8'd0);
      r_collect(1);
      chk("R5", "count with lone half pending", rbuf[0], 32'd2);
      chk("R5", "count r_last", 32'(rlast_b[0]), 32'h1);
      ar_send(8'h04, 4'd9, 8'd1);
      r_collect(2);
      chk("R4", "packed word 0", rbuf[0], 32'h2222_1111);
      chk("R6", "packed word 1", rbuf[1], 32'h4444_3333);
      chk("R6", "r_last per beat", {30'b0, rlast_b[0], rlast_b[1]}, 32'h1);
      chk("R6", "r_id", 32'(rid_b), 32'h9);
      chk("R6", "r_resp after burst", 32'(r_resp), 32'h0);
      hin_send(16'h6666);
      ar_send(8'h00, 4'd1, 8'd0);
      r_collect(1);
      chk("R5", "count after completing half", rbuf[0], 32'd1);
      ar_send(8'h04, 4'd1, 8'd0);
      r_collect(1);
      chk("R4", "word spanning reads", rbuf[0], 32'h6666_5555);
   endtask

   task automatic t_empty_stall;
      int bad = 0;
      ar_send(8'h04, 4'd5, 8'd0);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); #1;
         if (r_valid) bad++;
      end
      chk("R7", "r_valid cycles while empty", 32'(bad), 32'h0);
      hin_send(16'h7777);
      #1;
      chk("R7", "r_valid with half only", 32'(r_valid), 32'h0);
      hin_send(16'h8888);
      r_collect(1);
      chk("R7", "word after stall", rbuf[0], 32'h8888_7777);
      chk("R7", "r_id after stall", 32'(rid_b), 32'h5);
   endtask

   task automatic t_rx_full;
      for (int k = 0; k < 8; k++) begin
         hin_send(16'h0100 + 16'(k));
         hin_send(16'h0200 + 16'(k));
      end
      hin_send(16'hBEEF);
      @(negedge clk);
      tb_hin_valid = 1'b1; tb_hin_data = 16'hCAFE;
      #1;
      chk("R9", "hin_ready for completing half when full", 32'(hin_ready), 32'h0);
      wait_cyc(3); #1;
      chk("R9", "hin_ready still low", 32'(hin_ready), 32'h0);
      ar_send(8'h04, 4'd1, 8'd0);
      r_collect(1);
      chk("R9", "first popped word", rbuf[0], 32'h0200_0100);
      #1;
      chk("R9", "hin_ready after pop", 32'(hin_ready), 32'h1);
      @(negedge clk);
      tb_hin_valid = 1'b0;
      ar_send(8'h00, 4'd1, 8'd0);
      r_collect(1);
      chk("R9", "count after refill", rbuf[0], 32'd8);
      ar_send(8'h04, 4'd4, 8'd7);
      r_collect(8);
      for (int k = 1; k < 8; k++)
         chk("R9", "queued word", rbuf[k-1], {16'h0200 + 16'(k), 16'h0100 + 16'(k)});
      chk("R9", "word held back by full queue", rbuf[7], 32'hCAFE_BEEF);
   endtask

   task automatic t_ctrl_reset;
      int base;
      tb_hout_ready = 1'b1;
      hq.delete();
      base = rst_cnt;
      wbuf[0] = 32'hDEAD_BEEF;
      aw_send(8'h7C, 4'd6);
      w_send(1);
      b_get(4'd6, "R8");
      wait_cyc(5);
      chk("R8", "reset pulse count", 32'(rst_cnt - base), 32'd1);
      chk("R8", "pulse cycle after last beat", 32'(rst_cyc), 32'(w_cyc + 1));
      chk("R8", "halves from control write", 32'(hq.size()), 32'd0);
   endtask

   task automatic t_unmapped;
      hq.delete();
      wbuf[0] = 32'h1234_5678;
      aw_send(8'h40, 4'd8);
      w_send(1);
      b_get(4'd8, "R11");
      wait_cyc(10);
      chk("R11", "halves from unmapped write", 32'(hq.size()), 32'd0);
      ar_send(8'h40, 4'd2, 8'd1);
      r_collect(2);
      chk("R11", "unmapped beat 0", rbuf[0], 32'h0);
      chk("R11", "unmapped beat 1", rbuf[1], 32'h0);
      chk("R11", "unmapped r_last", {30'b0, rlast_b[0], rlast_b[1]}, 32'h1);
   endtask

   task automatic t_loopback;
      @(negedge clk);
      loop_en = 1'b1;
      for (int i = 0; i < 4; i++) wbuf[i] = 32'h5A00_0000 ^ (32'(i + 1) * 32'h0013_0707);
      aw_send(8'h00, 4'd1);
      w_send(4);
      b_get(4'd1, "R10");
      wait_cyc(30);
      ar_send(8'h00, 4'd1, 8'd0);
      r_collect(1);
      chk("R10", "count after loopback", rbuf[0], 32'd4);
      ar_send(8'h04, 4'd2, 8'd3);
      r_collect(4);
      for (int i = 0; i < 4; i++) chk("R10", "looped word", rbuf[i], wbuf[i]);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_push_burst();
      t_tx_full();
      t_pack_count();
      t_empty_stall();
      t_rx_full();
      t_ctrl_reset();
      t_unmapped();
      t_loopback();
      wait_cyc(5);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL all requirements watchdog: actual %0d cycles expected fewer", 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule